// File: doc/BRIEF.md
# Hinted conditional-branch resolver

This block sits between decode and fetch of a small in-order pipeline and owns every conditional branch. When decode presents a branch, the block forms a predicted next PC at once. An explicit direction bit in the instruction sets the prediction. A branch without that bit falls back to a rule based on where its target lies. The block then holds the branch until the condition flag of the latest compare is known. At that point it decides the real direction and, on a wrong guess, asks fetch to throw away the wrong-path work and restart at the correct address.

The refill cost of a wrong guess is not fixed. Every instruction that issued between the flag-setting compare and the branch hides one cycle of it. The block counts that distance and stalls only for the part of the penalty that is left. A correct guess costs nothing, and another branch may be accepted in the same cycle the previous one resolves.

Top module: `bhint_resolver`

## Requirements
- R1: After a synchronous active-high reset, `flush` and `stall` are low, no branch is pending, and the distance count is zero.
- R2: For a hinted branch (`br_hinted`=1), `pred_taken` equals `br_kind[0]` (1 = expect taken). `pred_pc` is `br_target` when `pred_taken` is 1, and otherwise `br_pc + br_len` modulo 2^PC_W.
- R3: For a branch without a hint, `pred_taken` is 1 when `br_target <= br_pc` (a backward target or a branch to itself), and 0 for a forward target. `pred_pc` follows as in R2.
- R4: A branch is taken when the flag value equals `br_kind[1]` (1 = branch on flag true, 0 = branch on flag false). When the outcome matches the prediction, `flush` stays low and no stall follows.
- R5: On a mispredict, `flush` is high for exactly one cycle, in the cycle the branch resolves. In that cycle `redirect_pc` is the branch target if the branch was taken, or the fall-through address (branch PC + length) if it was not.
- R6: After a mispredict flush, `stall` is high for exactly max(0, 3 - d) consecutive cycles, starting in the next cycle. Here d is the distance count captured when the branch was accepted.
- R7: The distance count drops to 0 on `cmp_issue`. It rises by one for each cycle with `inst_issue` and saturates at 3. It is observable through the stall length of R6.
- R8: `br_accept` is low while `stall` is high and while an earlier branch is still pending. The only exception is the cycle in which that pending branch resolves correctly.
- R9: A pending branch resolves only once the flag is known: `flag_upd` high in the current cycle, or a `flag_upd` since the last `cmp_issue`. Until then `flush` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Decode presents a conditional branch |
| br_hinted | input | 1 | Branch carries an explicit direction hint |
| br_kind | input | 2 | [1] condition polarity, [0] expected direction |
| br_pc | input | PC_W | Address of the branch |
| br_target | input | PC_W | Branch target address |
| br_len | input | LEN_W | Branch instruction length |
| inst_issue | input | 1 | An instruction issued this cycle |
| cmp_issue | input | 1 | A flag-setting compare issued this cycle |
| flag_upd | input | 1 | Compare result is delivered this cycle |
| flag_val | input | 1 | Delivered flag value |
| br_accept | output | 1 | Presented branch is taken into the resolver |
| pred_taken | output | 1 | Predicted direction of the presented branch |
| pred_pc | output | PC_W | Predicted next fetch address |
| flush | output | 1 | Mispredict: discard wrong-path work |
| redirect_pc | output | PC_W | Corrected fetch address, valid with flush |
| stall | output | 1 | Hold fetch for the remaining penalty |

## Verification
The assertions rely on two conditions of the pipeline. No compare issues while a branch is pending or in the cycle one is accepted, and a compare and its flag delivery never share a cycle. The random stimulus holds to both: it reads the bench model's pending state before it raises `cmp_issue`, and it lowers `br_valid` and `flag_upd` in any cycle that carries a compare. The directed cases hold to them as well. They walk through the distances 0 to 5 with forced mispredicts, cover the four branch variants and both fallback directions, and hold a branch waiting for a late flag.

// File: rtl/bhr_pkg.sv
package bhr_pkg;

   // bit positions inside the branch kind field
   localparam int KIND_POL_BIT = 1;   // 1: branch when flag true
   localparam int KIND_EXP_BIT = 0;   // 1: expect taken

   typedef enum logic [1:0] {
      BK_FALSE_EXP_NT = 2'b00,
      BK_FALSE_EXP_T  = 2'b01,
      BK_TRUE_EXP_NT  = 2'b10,
      BK_TRUE_EXP_T   = 2'b11
   } br_kind_e;

   function automatic logic kind_pol(input logic [1:0] k);
      return k[KIND_POL_BIT];
   endfunction

   function automatic logic kind_exp(input logic [1:0] k);
      return k[KIND_EXP_BIT];
   endfunction

endpackage

// File: rtl/bhr_hint_dec.sv
module bhr_hint_dec
   import bhr_pkg::*;
#(
   parameter int PC_W          = 32,
   parameter int LEN_W         = 3,
   parameter bit FALLBACK_BTFN = 1'b1
) (
   input  logic             hinted,
   input  logic [1:0]       kind,
   input  logic [PC_W-1:0]  pc,
   input  logic [PC_W-1:0]  target,
   input  logic [LEN_W-1:0] len,
   output logic             pred_taken,
   output logic             pol,
   output logic [PC_W-1:0]  pred_pc,
   output logic [PC_W-1:0]  fall_pc
);

   logic fallback_taken;

   generate
      if (FALLBACK_BTFN) begin : g_btfn
         // backward (or self) target predicted taken
         assign fallback_taken = (target <= pc);
      end else begin : g_static_nt
         assign fallback_taken = 1'b0;
      end
   endgenerate

   always_comb begin
      fall_pc    = pc + PC_W'(len);
      pred_taken = hinted ? kind_exp(kind) : fallback_taken;
      pol        = kind_pol(kind);
      pred_pc    = pred_taken ? target : fall_pc;
   end

endmodule

// File: rtl/bhr_dist_ctr.sv
module bhr_dist_ctr #(
   parameter int MAX_PENALTY = 3,
   parameter int DW          = $clog2(MAX_PENALTY + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cmp_issue,
   input  logic          inst_issue,
   output logic [DW-1:0] dist_q
);

   localparam logic [DW-1:0] SAT = DW'(MAX_PENALTY);

   always_ff @(posedge clk) begin
      if (rst) begin
         dist_q <= '0;
      end else if (cmp_issue) begin
         dist_q <= '0;
      end else if (inst_issue && (dist_q != SAT)) begin
         dist_q <= dist_q + 1'b1;
      end
   end

endmodule

// File: rtl/bhr_resolve.sv
module bhr_resolve #(
   parameter int PC_W        = 32,
   parameter int MAX_PENALTY = 3,
   parameter int DW          = $clog2(MAX_PENALTY + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cmp_issue,
   input  logic            flag_upd,
   input  logic            flag_val,
   input  logic            br_valid,
   input  logic            dec_pol,
   input  logic            dec_pred,
   input  logic [PC_W-1:0] dec_target,
   input  logic [PC_W-1:0] dec_fall,
   input  logic [DW-1:0]   dist_q,
   output logic            br_accept,
   output logic            flush,
   output logic [PC_W-1:0] redirect_pc,
   output logic            stall
);

   localparam logic [DW-1:0] PEN_MAX = DW'(MAX_PENALTY);

   // pending branch record
   logic            pend_q;
   logic            pol_q;
   logic            pred_q;
   logic [PC_W-1:0] tgt_q;
   logic [PC_W-1:0] fall_q;
   logic [DW-1:0]   pdist_q;

   // flag tracking and stall countdown
   logic            flag_q;
   logic            rdy_q;
   logic [DW-1:0]   stall_q;

   logic flag_now, rdy_now, resolve, taken, miss;

   always_comb begin
      flag_now    = flag_upd ? flag_val : flag_q;
      rdy_now     = flag_upd | rdy_q;
      resolve     = pend_q & rdy_now;
      taken       = (flag_now == pol_q);
      miss        = resolve & (taken != pred_q);
      flush       = miss;
      redirect_pc = taken ? tgt_q : fall_q;
      stall       = (stall_q != '0);
      br_accept   = br_valid & ~stall & (~pend_q | (resolve & ~miss));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stall_q <= '0;
      end else if (miss) begin
         stall_q <= PEN_MAX - pdist_q;
      end else if (stall) begin
         stall_q <= stall_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q  <= 1'b0;
         pol_q   <= 1'b0;
         pred_q  <= 1'b0;
         tgt_q   <= '0;
         fall_q  <= '0;
         pdist_q <= '0;
      end else if (br_accept) begin
         pend_q  <= 1'b1;
         pol_q   <= dec_pol;
         pred_q  <= dec_pred;
         tgt_q   <= dec_target;
         fall_q  <= dec_fall;
         pdist_q <= dist_q;
      end else if (resolve) begin
         pend_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdy_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (cmp_issue) begin
            rdy_q <= 1'b0;
         end else if (flag_upd) begin
            rdy_q <= 1'b1;
         end
         if (flag_upd) begin
            flag_q <= flag_val;
         end
      end
   end

endmodule

// File: rtl/bhint_resolver.sv
module bhint_resolver #(
   parameter int PC_W          = 32,
   parameter int LEN_W         = 3,
   parameter int MAX_PENALTY   = 3,
   parameter bit FALLBACK_BTFN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             br_valid,
   input  logic             br_hinted,
   input  logic [1:0]       br_kind,
   input  logic [PC_W-1:0]  br_pc,
   input  logic [PC_W-1:0]  br_target,
   input  logic [LEN_W-1:0] br_len,
   input  logic             inst_issue,
   input  logic             cmp_issue,
   input  logic             flag_upd,
   input  logic             flag_val,
   output logic             br_accept,
   output logic             pred_taken,
   output logic [PC_W-1:0]  pred_pc,
   output logic             flush,
   output logic [PC_W-1:0]  redirect_pc,
   output logic             stall
);

   localparam int DW = $clog2(MAX_PENALTY + 1);

   generate
      if (PC_W < 8)                 $error("PC_W must be at least 8");
      if (LEN_W < 1 || LEN_W > PC_W) $error("LEN_W out of range");
      if (MAX_PENALTY < 1)          $error("MAX_PENALTY must be at least 1");
   endgenerate

   logic            dec_pol;
   logic [PC_W-1:0] dec_fall;
   logic [DW-1:0]   dist_q;

   bhr_hint_dec #(
      .PC_W         (PC_W),
      .LEN_W        (LEN_W),
      .FALLBACK_BTFN(FALLBACK_BTFN)
   ) hint_dec_i (
      .hinted    (br_hinted),
      .kind      (br_kind),
      .pc        (br_pc),
      .target    (br_target),
      .len       (br_len),
      .pred_taken(pred_taken),
      .pol       (dec_pol),
      .pred_pc   (pred_pc),
      .fall_pc   (dec_fall)
   );

   bhr_dist_ctr #(
      .MAX_PENALTY(MAX_PENALTY),
      .DW         (DW)
   ) dist_ctr_i (
      .clk       (clk),
      .rst       (rst),
      .cmp_issue (cmp_issue),
      .inst_issue(inst_issue),
      .dist_q    (dist_q)
   );

   bhr_resolve #(
      .PC_W       (PC_W),
      .MAX_PENALTY(MAX_PENALTY),
      .DW         (DW)
   ) resolve_i (
      .clk        (clk),
      .rst        (rst),
      .cmp_issue  (cmp_issue),
      .flag_upd   (flag_upd),
      .flag_val   (flag_val),
      .br_valid   (br_valid),
      .dec_pol    (dec_pol),
      .dec_pred   (pred_taken),
      .dec_target (br_target),
      .dec_fall   (dec_fall),
      .dist_q     (dist_q),
      .br_accept  (br_accept),
      .flush      (flush),
      .redirect_pc(redirect_pc),
      .stall      (stall)
   );

endmodule

// File: rtl/bhint_resolver_chk.sv
module bhint_resolver_chk #(
   parameter int MAX_PENALTY = 3
) (
   input logic       clk,
   input logic       rst,
   input logic       br_valid,
   input logic       br_hinted,
   input logic [1:0] br_kind,
   input logic       br_accept,
   input logic       pred_taken,
   input logic       flush,
   input logic       stall
);

   logic [7:0] stall_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         stall_run <= '0;
      end else if (stall) begin
         stall_run <= stall_run + 1'b1;
      end else begin
         stall_run <= '0;
      end
   end

   // R5: flush never lasts more than one cycle
   a_r5_flush_single: assert property (@(posedge clk) disable iff (rst)
      flush |=> !flush);

   // R6: a stall burst only begins right after a flush
   a_r6_stall_after_flush: assert property (@(posedge clk) disable iff (rst)
      $rose(stall) |-> $past(flush));

   // R6: stall burst never exceeds the maximum penalty
   a_r6_stall_bound: assert property (@(posedge clk) disable iff (rst)
      stall |-> (stall_run < 8'(MAX_PENALTY)));

   // R8: no acceptance during a stall
   a_r8_no_accept_in_stall: assert property (@(posedge clk) disable iff (rst)
      stall |-> !br_accept);

   // R8: acceptance needs a presented branch
   a_r8_accept_needs_valid: assert property (@(posedge clk) disable iff (rst)
      br_accept |-> br_valid);

   // R2: an explicit hint is followed
   a_r2_hint_followed: assert property (@(posedge clk) disable iff (rst)
      (br_valid && br_hinted) |-> (pred_taken == br_kind[0]));

endmodule

bind bhint_resolver bhint_resolver_chk #(
   .MAX_PENALTY(MAX_PENALTY)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .br_valid  (br_valid),
   .br_hinted (br_hinted),
   .br_kind   (br_kind),
   .br_accept (br_accept),
   .pred_taken(pred_taken),
   .flush     (flush),
   .stall     (stall)
);

// File: tb/bhint_resolver_tb_top.sv
module bhint_resolver_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W       = 32;
   localparam int LEN_W      = 3;
   localparam int MAXP       = 3;
   localparam int WD_LIMIT   = 100000;

   logic             clk = 1'b0;
   logic             rst;
   logic             br_valid, br_hinted;
   logic [1:0]       br_kind;
   logic [PC_W-1:0]  br_pc, br_target;
   logic [LEN_W-1:0] br_len;
   logic             inst_issue, cmp_issue, flag_upd, flag_val;
   logic             br_accept, pred_taken, flush, stall;
   logic [PC_W-1:0]  pred_pc, redirect_pc;

   int checks = 0;
   int errors = 0;
   int wd     = 0;

   // behavioural reference state
   bit              m_pend, m_rdy, m_flag;
   int              m_dist, m_stall;
   bit              p_pol, p_pred;
   logic [PC_W-1:0] p_tgt, p_fall;
   int              p_dist;
   bit              obs_stall, obs_flush, obs_acc;

   always #(CLK_PERIOD/2) clk = ~clk;

   bhint_resolver #(.PC_W(PC_W), .LEN_W(LEN_W), .MAX_PENALTY(MAXP)) dut_i (
      .clk(clk), .rst(rst), .br_valid(br_valid), .br_hinted(br_hinted),
      .br_kind(br_kind), .br_pc(br_pc), .br_target(br_target), .br_len(br_len),
      .inst_issue(inst_issue), .cmp_issue(cmp_issue), .flag_upd(flag_upd),
      .flag_val(flag_val), .br_accept(br_accept), .pred_taken(pred_taken),
      .pred_pc(pred_pc), .flush(flush), .redirect_pc(redirect_pc), .stall(stall)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      br_valid = 0; br_hinted = 0; br_kind = 2'b00;
      br_pc = '0; br_target = '0; br_len = '0;
      inst_issue = 0; cmp_issue = 0; flag_upd = 0; flag_val = 0;
   endtask

   task automatic model_reset();
      m_pend = 0; m_rdy = 0; m_flag = 0; m_dist = 0; m_stall = 0;
      p_pol = 0; p_pred = 0; p_tgt = '0; p_fall = '0; p_dist = 0;
   endtask

   // one clock: compare against the model, then advance the model
   task automatic cyc();
      bit e_rdy, e_flag, e_res, e_taken, e_miss, e_acc, e_pred, e_stall;
      logic [PC_W-1:0] e_ppc, e_redir, fall;
      #1;
      fall    = br_pc + PC_W'(br_len);
      e_rdy   = flag_upd || m_rdy;
      e_flag  = flag_upd ? flag_val : m_flag;
      e_res   = m_pend && e_rdy;
      e_taken = (e_flag == p_pol);
      e_miss  = e_res && (e_taken != p_pred);
      e_redir = e_taken ? p_tgt : p_fall;
      e_stall = (m_stall != 0);
      e_acc   = br_valid && !e_stall && (!m_pend || (e_res && !e_miss));
      e_pred  = br_hinted ? br_kind[0] : (br_target <= br_pc);
      e_ppc   = e_pred ? br_target : fall;

      chk(pred_taken == e_pred, br_hinted ? "R2" : "R3", "pred_taken", pred_taken, e_pred);
      chk(pred_pc == e_ppc, br_hinted ? "R2" : "R3", "pred_pc", pred_pc, e_ppc);
      chk(flush == e_miss, e_miss ? "R5" : "R4", "flush", flush, e_miss);
      if (e_miss) chk(redirect_pc == e_redir, "R5", "redirect_pc", redirect_pc, e_redir);
      chk(stall == e_stall, "R6", "stall", stall, e_stall);
      chk(br_accept == e_acc, "R8", "br_accept", br_accept, e_acc);
      obs_stall = stall; obs_flush = flush; obs_acc = br_accept;

      @(posedge clk);
      if (e_miss) m_stall = MAXP - p_dist;
      else if (m_stall > 0) m_stall--;
      if (e_acc) begin
         m_pend = 1; p_pol = br_kind[1]; p_pred = e_pred;
         p_tgt = br_target; p_fall = fall; p_dist = m_dist;
      end else if (e_res) m_pend = 0;
      if (cmp_issue) m_rdy = 0; else if (flag_upd) m_rdy = 1;
      if (flag_upd) m_flag = flag_val;
      if (cmp_issue) m_dist = 0;
      else if (inst_issue && m_dist < MAXP) m_dist++;
      @(negedge clk);
   endtask

   // compare, then d issued instructions, then a mispredicting branch
   task automatic miss_scenario(input int d, input bit taken_case);
      int n_stall, n_flush;
      idle_inputs(); cmp_issue = 1; cyc();
      for (int i = 0; i < d; i++) begin idle_inputs(); inst_issue = 1; cyc(); end
      idle_inputs();
      br_valid = 1; br_hinted = 1;
      br_pc = 32'h0000_1000 + 32'(d * 64); br_target = 32'h0000_4000 + 32'(d);
      br_len = 3'd4; flag_upd = 1;
      // taken_case: flag true, branch on true, hint not-taken; else flag false, hint taken
      br_kind = taken_case ? 2'b10 : 2'b11;
      flag_val = taken_case ? 1'b0 + 1'b1 : 1'b0;
      cyc();
      chk(obs_acc, "R8", "accept idle", obs_acc, 1);
      idle_inputs();
      n_stall = 0; n_flush = 0;
      for (int i = 0; i < 6; i++) begin
         cyc();
         if (obs_stall) n_stall++;
         if (obs_flush) n_flush++;
      end
      chk(n_flush == 1, "R5", "flush count", n_flush, 1);
      // R7: distance saturates, so the penalty is max(0, 3-d)
      chk(n_stall == ((d >= MAXP) ? 0 : MAXP - d), "R7", "stall length",
          n_stall, (d >= MAXP) ? 0 : MAXP - d);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         wd++;
         if (wd > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      int n_flush;
      idle_inputs();
      model_reset();
      rst = 1;
      repeat (3) @(negedge clk);
      rst = 0;

      // R1: reset state
      #1;
      chk(!flush, "R1", "flush after reset", flush, 0);
      chk(!stall, "R1", "stall after reset", stall, 0);
      cyc();

      // R2: all four hinted variants, both fall-through and target
      for (int k = 0; k < 4; k++) begin
         idle_inputs(); br_hinted = 1; br_kind = 2'(k);
         br_pc = 32'h0000_2000; br_target = 32'h0000_2100; br_len = 3'd2;
         cyc();
      end

      // R3: unhinted forward, backward, self, and wrap of fall-through
      idle_inputs(); br_pc = 32'h300; br_target = 32'h380; br_len = 3'd4; cyc();
      idle_inputs(); br_pc = 32'h300; br_target = 32'h280; br_len = 3'd4; cyc();
      idle_inputs(); br_pc = 32'h300; br_target = 32'h300; br_len = 3'd4; cyc();
      idle_inputs(); br_pc = 32'hFFFF_FFFE; br_target = 32'hFFFF_FFFF; br_len = 3'd4; cyc();

      // R6/R7: mispredicts at distances 0..5, both outcomes
      for (int d = 0; d <= 5; d++) begin
         miss_scenario(d, 1'b1);
         miss_scenario(d, 1'b0);
      end

      // R4: correct prediction, no flush, back-to-back accept
      idle_inputs(); cmp_issue = 1; cyc();
      idle_inputs(); br_valid = 1; br_hinted = 1; br_kind = 2'b11;
      br_pc = 32'h500; br_target = 32'h600; br_len = 3'd2; flag_upd = 1; flag_val = 1;
      cyc();
      idle_inputs(); br_valid = 1; br_hinted = 1; br_kind = 2'b00;
      br_pc = 32'h600; br_target = 32'h700; br_len = 3'd2;
      cyc();
      chk(obs_acc, "R4", "back-to-back accept", obs_acc, 1);
      chk(!obs_flush, "R4", "no flush on hit", obs_flush, 0);
      idle_inputs(); repeat (3) cyc();

      // R9: branch waits for a late flag
      idle_inputs(); cmp_issue = 1; cyc();
      idle_inputs(); br_valid = 1; br_hinted = 1; br_kind = 2'b10;
      br_pc = 32'h800; br_target = 32'h900; br_len = 3'd4;
      cyc();
      n_flush = 0;
      for (int i = 0; i < 4; i++) begin
         idle_inputs(); cyc();
         if (obs_flush) n_flush++;
      end
      chk(n_flush == 0, "R9", "flush before flag", n_flush, 0);
      idle_inputs(); flag_upd = 1; flag_val = 1; cyc();
      chk(obs_flush, "R9", "flush when flag arrives", obs_flush, 1);
      // R8: branch presented during the stall is refused
      idle_inputs(); br_valid = 1; br_hinted = 1; br_kind = 2'b01;
      br_pc = 32'hA00; br_target = 32'hB00; br_len = 3'd2;
      cyc();
      chk(!obs_acc, "R8", "accept during stall", obs_acc, 0);
      idle_inputs(); repeat (4) cyc();

      // random traffic within the input assumptions
      for (int i = 0; i < 4000; i++) begin
         idle_inputs();
         if (!m_pend && ($urandom_range(0, 7) == 0)) begin
            cmp_issue = 1;
            inst_issue = $urandom_range(0, 1);
         end else begin
            br_valid   = ($urandom_range(0, 2) == 0);
            br_hinted  = $urandom_range(0, 1);
            br_kind    = 2'($urandom_range(0, 3));
            br_pc      = 32'($urandom_range(0, 255)) << 2;
            br_target  = 32'($urandom_range(0, 255)) << 2;
            br_len     = 3'($urandom_range(1, 7));
            inst_issue = $urandom_range(0, 1);
            flag_upd   = ($urandom_range(0, 3) == 0);
            flag_val   = $urandom_range(0, 1);
         end
         cyc();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule